// File: doc/BRIEF.md
# Two-Wire Serial Bus Control and Status Unit

This unit holds the control and status logic of a two-wire clocked serial port. Software reaches it through a small write/read register interface. From it, software can force the line conditions that open and close bus traffic, read flags that report those conditions when they appear on the bus, and choose how the acknowledge bit is produced. A byte counter follows the serial clock. It shifts in one received byte, MSB first, and the unit compares an address byte against a stored slave address.

The serial clock and data inputs are sampled on the system clock. The unit drives one serial data output. That output is the output latch value, pulled low for a whole serial clock period when an acknowledge is sent. Control bits of the register word: bit 0 forces a release level, bit 1 forces a command level, bit 2 requests one acknowledge, bit 3 enables the automatic acknowledge, bit 4 is the release flag and bit 5 is the command flag. Bits 0 to 2 are write-only triggers. Bits 4 and 5 are read-only.

Top module: `sbc_top`

## Requirements
- R1: A control write with bit 0 set makes the output latch 1, so `sdaOut` is 1 when no acknowledge is active. Bit 0 always reads back as 0.
- R2: A control write with bit 1 set and bit 0 clear makes the output latch 0. Bit 1 always reads back as 0.
- R3: A rising data line while the clock line is high sets the release flag, read as bit 4 of `ctlRd`.
- R4: The release flag is cleared by a transfer start, by `serEn` low, and by a received address byte that differs from the slave address. A matching address byte leaves it set.
- R5: A falling data line while the clock line is high sets the command flag, read as bit 5 of `ctlRd`.
- R6: The command flag is cleared by a later release condition, by a transfer start and by `serEn` low.
- R7: When bit 3 (acknowledge enable) is 1 as the 8th bit of a byte arrives, `sdaOut` is driven low from the following clock fall until the fall after the 9th clock rise.
- R8: When bit 3 is 0, no acknowledge is driven on the 9th clock, and `sdaOut` follows the latch.
- R9: When bit 3 is written from 0 to 1 after the 8th bit and before the 9th clock, an acknowledge is driven on the 9th clock.
- R10: A control write with bit 2 set after the 8th bit drives an acknowledge on the next serial clock, with bit 3 at 0. A later write with bit 2 at 0 does not cancel it, and bit 2 reads back as 0.
- R11: After the 8th bit, `rxData` holds the byte received MSB first. After an address transfer, `addrMatch` is 1 only if that byte equals the slave address.
- R12: After reset, `ctlRd` is 0, `sdaOut` is 1 and `addrMatch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serEn | input | 1 | Serial port enable; low clears the flags and the transfer |
| xferStart | input | 1 | One-cycle transfer start strobe |
| addrPhase | input | 1 | Marks the started transfer as an address byte |
| ctlWr | input | 1 | Control register write strobe |
| slvWr | input | 1 | Slave address write strobe |
| wrData | input | DATA_W | Write data for both registers |
| ctlRd | output | DATA_W | Control and status readback |
| sclIn | input | 1 | Serial clock line |
| sdaIn | input | 1 | Serial data line |
| sdaOut | output | 1 | Serial data drive (latch or acknowledge low) |
| rxData | output | DATA_W | Last received byte |
| addrMatch | output | 1 | Address byte equalled slave address |

## Verification
The properties assume that `sclIn` and `sdaIn` are already synchronous to `clk`, and that every line level lasts several system clocks. Under that assumption one sample register is enough to see every edge, and an acknowledge always begins in a clock-low phase. The stimulus holds each line level for four system clocks. It changes the data line only while the clock line is low, except when it makes a release or command condition on purpose. It also never writes both force bits in the same word.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int BIT_FORCE_HI = 0;
  localparam int BIT_FORCE_LO = 1;
  localparam int BIT_ACK_REQ  = 2;
  localparam int BIT_ACK_EN   = 3;
  localparam int BIT_REL_FLAG = 4;
  localparam int BIT_CMD_FLAG = 5;
  localparam int CTL_WR_W     = 4;

  typedef struct packed {
    logic startXfer;
    logic addrPhase;
    logic setLatch;
    logic clrLatch;
    logic ackLow;
    logic halt;
  } sbcStrobe_t;

  typedef struct packed {
    logic sclHigh;
    logic sclRise;
    logic sclFall;
    logic relSeen;
    logic cmdSeen;
    logic byteDone;
    logic addrMiss;
    logic ackSlot;
  } sbcEvent_t;
endpackage

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbcStrobe_t        strb,
  input  logic              slvWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output sbcEvent_t         evt,
  output logic              soLatch,
  output logic              sdaOut,
  output logic [DATA_W-1:0] rxData,
  output logic              addrMatch
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_CNT   = CNT_W'(DATA_W);

  logic sclQ, sclPrev, sdaQ, sdaPrev;
  logic [CNT_W-1:0] bitCnt;
  logic busy, isAddr, matchQ, latchQ;
  logic [DATA_W-1:0] shiftQ, slvAddr, nextShift;
  logic riseNow, byteNow;

  // line sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1; sclPrev <= 1'b1;
      sdaQ <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclQ <= sclIn; sclPrev <= sclQ;
      sdaQ <= sdaIn; sdaPrev <= sdaQ;
    end
  end

  assign riseNow   = sclQ & ~sclPrev;
  assign nextShift = {shiftQ[DATA_W-2:0], sdaQ};
  assign byteNow   = riseNow & busy & (bitCnt == LAST_DATA);

  // bit counter and receive shift
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; bitCnt <= '0; isAddr <= 1'b0;
      shiftQ <= '0; matchQ <= 1'b0;
    end else if (strb.halt) begin
      busy <= 1'b0; bitCnt <= '0; matchQ <= 1'b0;
    end else if (strb.startXfer) begin
      busy <= 1'b1; bitCnt <= '0; matchQ <= 1'b0;
      isAddr <= strb.addrPhase;
    end else if (riseNow && busy) begin
      if (bitCnt == ACK_CNT) begin
        busy <= 1'b0;
        bitCnt <= '0;
      end else begin
        shiftQ <= nextShift;
        bitCnt <= bitCnt + 1'b1;
      end
      if (byteNow && isAddr) matchQ <= (nextShift == slvAddr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slvAddr <= '0;
    else if (slvWr) slvAddr <= wrData;
  end

  // output latch: release force wins over command force
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= 1'b1;
    else if (strb.setLatch) latchQ <= 1'b1;
    else if (strb.clrLatch) latchQ <= 1'b0;
  end

  always_comb begin
    evt.sclHigh  = sclQ;
    evt.sclRise  = riseNow;
    evt.sclFall  = ~sclQ & sclPrev;
    evt.relSeen  = sclQ & sclPrev & sdaQ & ~sdaPrev;
    evt.cmdSeen  = sclQ & sclPrev & ~sdaQ & sdaPrev;
    evt.byteDone = byteNow;
    evt.addrMiss = byteNow & isAddr & (nextShift != slvAddr);
    evt.ackSlot  = busy & (bitCnt == ACK_CNT);
  end

  assign soLatch   = latchQ;
  assign sdaOut    = strb.ackLow ? 1'b0 : latchQ;
  assign rxData    = shiftQ;
  assign addrMatch = matchQ;
endmodule

// File: rtl/sbc_control.sv
module sbc_control
  import sbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serEn,
  input  logic                xferStart,
  input  logic                addrPhase,
  input  logic                ctlWr,
  input  logic [CTL_WR_W-1:0] ctlBits,
  input  sbcEvent_t           evt,
  output sbcStrobe_t          strb,
  output logic [DATA_W-1:0]   ctlRd
);
  logic ackEnQ, relDetQ, cmdDetQ, ackReqQ, ackOnQ, sawRiseQ;
  logic startNow, reqNew, lateEnable;

  assign startNow   = xferStart & serEn;
  assign lateEnable = ctlWr & ctlBits[BIT_ACK_EN] & ~ackEnQ & evt.ackSlot;
  assign reqNew     = (evt.byteDone & ackEnQ) | lateEnable
                    | (ctlWr & ctlBits[BIT_ACK_REQ]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackEnQ <= 1'b0;
    else if (ctlWr) ackEnQ <= ctlBits[BIT_ACK_EN];
  end

  // detect flags, clears take priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relDetQ <= 1'b0; cmdDetQ <= 1'b0;
    end else begin
      if (!serEn || startNow || evt.addrMiss) relDetQ <= 1'b0;
      else if (evt.relSeen) relDetQ <= 1'b1;
      if (!serEn || startNow || evt.relSeen) cmdDetQ <= 1'b0;
      else if (evt.cmdSeen) cmdDetQ <= 1'b1;
    end
  end

  // acknowledge: start in a clock-low phase, hold through one full clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackReqQ <= 1'b0; ackOnQ <= 1'b0; sawRiseQ <= 1'b0;
    end else if (!serEn) begin
      ackReqQ <= 1'b0; ackOnQ <= 1'b0; sawRiseQ <= 1'b0;
    end else begin
      if (ackOnQ) begin
        if (evt.sclRise) sawRiseQ <= 1'b1;
        if (evt.sclFall && sawRiseQ) begin
          ackOnQ <= 1'b0; sawRiseQ <= 1'b0;
        end
      end else if (ackReqQ && !evt.sclHigh) begin
        ackOnQ <= 1'b1; ackReqQ <= 1'b0; sawRiseQ <= 1'b0;
      end
      if (reqNew) ackReqQ <= 1'b1;
    end
  end

  always_comb begin
    strb.startXfer = startNow;
    strb.addrPhase = addrPhase;
    strb.setLatch  = ctlWr & ctlBits[BIT_FORCE_HI];
    strb.clrLatch  = ctlWr & ctlBits[BIT_FORCE_LO];
    strb.ackLow    = ackOnQ;
    strb.halt      = ~serEn;
  end

  always_comb begin
    ctlRd = '0;
    ctlRd[BIT_ACK_EN]   = ackEnQ;
    ctlRd[BIT_REL_FLAG] = relDetQ;
    ctlRd[BIT_CMD_FLAG] = cmdDetQ;
  end
endmodule

// File: rtl/sbc_top.sv
module sbc_top
  import sbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serEn,
  input  logic              xferStart,
  input  logic              addrPhase,
  input  logic              ctlWr,
  input  logic              slvWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctlRd,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic [DATA_W-1:0] rxData,
  output logic              addrMatch
);
  sbcStrobe_t strb;
  sbcEvent_t  evt;
  logic       soLatch;

  sbc_control #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .serEn(serEn), .xferStart(xferStart),
    .addrPhase(addrPhase), .ctlWr(ctlWr), .ctlBits(wrData[CTL_WR_W-1:0]),
    .evt(evt), .strb(strb), .ctlRd(ctlRd)
  );

  sbc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .slvWr(slvWr), .wrData(wrData),
    .sclIn(sclIn), .sdaIn(sdaIn), .evt(evt), .soLatch(soLatch),
    .sdaOut(sdaOut), .rxData(rxData), .addrMatch(addrMatch)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       serEn,
  input logic       xferStart,
  input logic       ctlWr,
  input logic [1:0] forceBits,
  input logic [1:0] flagBits,
  input logic       soLatch,
  input logic       ackLow,
  input logic       sclHigh
);
  a_r1_force_high: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && forceBits[0]) |=> soLatch);

  a_r2_force_low: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && forceBits[1] && !forceBits[0]) |=> !soLatch);

  // R4 and R6: start clears both flags
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart && serEn) |=> (flagBits == 2'b00));

  // R4 and R6: disable clears both flags
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    !serEn |=> (flagBits == 2'b00));

  a_r7_ack_starts_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackLow) |-> !$past(sclHigh));
endmodule

bind sbc_top sbc_checker u_chk (
  .clk(clk), .rstN(rstN), .serEn(serEn), .xferStart(xferStart),
  .ctlWr(ctlWr), .forceBits(wrData[1:0]), .flagBits(ctlRd[5:4]),
  .soLatch(soLatch), .ackLow(strb.ackLow), .sclHigh(evt.sclHigh)
);

// File: tb/tb_sbc_top.sv
`timescale 1ns/1ps
module tb_sbc_top;
  localparam int DATA_W = 8;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b1, xferStart = 1'b0, addrPhase = 1'b0;
  logic ctlWr = 1'b0, slvWr = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] ctlRd, rxData;
  logic sclIn = 1'b1, sdaIn = 1'b1;
  logic sdaOut, addrMatch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sbc_top #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .serEn(serEn), .xferStart(xferStart),
    .addrPhase(addrPhase), .ctlWr(ctlWr), .slvWr(slvWr), .wrData(wrData),
    .ctlRd(ctlRd), .sclIn(sclIn), .sdaIn(sdaIn), .sdaOut(sdaOut),
    .rxData(rxData), .addrMatch(addrMatch)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expCtl(bit rel, bit cmd, bit ae);
    return (int'(cmd) << 5) | (int'(rel) << 4) | (int'(ae) << 3);
  endfunction

  task automatic waitH();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic writeCtl(logic [7:0] v);
    @(negedge clk); ctlWr = 1'b1; wrData = v;
    @(negedge clk); ctlWr = 1'b0; wrData = '0;
  endtask

  task automatic writeSlv(logic [7:0] v);
    @(negedge clk); slvWr = 1'b1; wrData = v;
    @(negedge clk); slvWr = 1'b0; wrData = '0;
  endtask

  task automatic pulseStart(bit a);
    @(negedge clk); xferStart = 1'b1; addrPhase = a;
    @(negedge clk); xferStart = 1'b0; addrPhase = 1'b0;
  endtask

  task automatic ninth(output bit hi, output bit lo);
    sclIn = 1'b0; sdaIn = 1'b1; waitH(); waitH();
    sclIn = 1'b1; waitH(); hi = sdaOut;
    sclIn = 1'b0; waitH(); lo = sdaOut;
  endtask

  // mode: 0 none, 1 enable written after 8th bit, 2 request bit after 8th bit
  task automatic runByte(logic [7:0] b, bit isAddr, bit preRel, bit aePre,
                         int mode, logic [7:0] slv, string tag);
    bit hi, lo, expHi, expRel, expAe;
    logic [7:0] base;
    base = aePre ? 8'h09 : 8'h01;
    writeCtl(base);
    sclIn = 1'b0; waitH(); sdaIn = 1'b0; waitH(); sclIn = 1'b1; waitH();
    pulseStart(isAddr); waitH();
    if (preRel) begin sdaIn = 1'b1; waitH(); end
    for (int i = 7; i >= 0; i--) begin
      sclIn = 1'b0; waitH(); sdaIn = b[i]; waitH(); sclIn = 1'b1; waitH();
    end
    if (mode == 2) begin writeCtl(base | 8'h04); writeCtl(base); end
    sclIn = 1'b0; waitH();
    if (mode == 1) writeCtl(8'h09);
    ninth(hi, lo);
    expHi  = !(aePre || mode != 0);
    expRel = preRel && !(isAddr && b != slv);
    expAe  = aePre || mode == 1;
    chk({tag, " R7/R8/R9/R10 ack level on 9th clock"}, int'(hi), int'(expHi));
    chk({tag, " R7 line released after 9th clock"}, int'(lo), 1);
    chk({tag, " R11 rxData"}, int'(rxData), int'(b));
    chk({tag, " R11 addrMatch"}, int'(addrMatch), int'(isAddr && b == slv));
    chk({tag, " R4 flags after byte"}, int'(ctlRd), expCtl(expRel, 1'b0, expAe));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] slv, b;
    bit isA, pre, ae;
    int mode;
    void'($urandom(32'h5bc1));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitH();
    chk("R12 ctlRd after reset", int'(ctlRd), 0);
    chk("R12 sdaOut after reset", int'(sdaOut), 1);
    chk("R12 addrMatch after reset", int'(addrMatch), 0);

    writeCtl(8'h02); waitH();
    chk("R2 force low", int'(sdaOut), 0);
    chk("R2 trigger reads 0", int'(ctlRd), 0);
    writeCtl(8'h01); waitH();
    chk("R1 force high", int'(sdaOut), 1);
    chk("R1 trigger reads 0", int'(ctlRd), 0);

    sdaIn = 1'b0; waitH();
    chk("R5 command sets flag", int'(ctlRd), expCtl(0, 1, 0));
    sdaIn = 1'b1; waitH();
    chk("R3 R6 release sets, clears command", int'(ctlRd), expCtl(1, 0, 0));
    pulseStart(1'b0); waitH();
    chk("R4 start clears release", int'(ctlRd), 0);
    sdaIn = 1'b0; waitH();
    chk("R5 command again", int'(ctlRd), expCtl(0, 1, 0));
    pulseStart(1'b0); waitH();
    chk("R6 start clears command", int'(ctlRd), 0);
    sdaIn = 1'b1; waitH(); sdaIn = 1'b0; waitH();
    chk("R3 R5 both flags", int'(ctlRd), expCtl(1, 1, 0));
    serEn = 1'b0; waitH();
    chk("R4 R6 disable clears flags", int'(ctlRd), 0);
    serEn = 1'b1; sdaIn = 1'b1; waitH();
    chk("R3 release after enable", int'(ctlRd), expCtl(1, 0, 0));

    slv = 8'hA5;
    writeSlv(slv);
    runByte(8'hA5, 1, 1, 1, 0, slv, "match auto");
    runByte(8'h5A, 1, 1, 0, 0, slv, "miss no-ack");
    runByte(8'h3C, 0, 1, 0, 1, slv, "late enable");
    runByte(8'hC3, 0, 0, 0, 2, slv, "request bit");

    for (int k = 0; k < 8; k++) begin
      slv = 8'($urandom);
      writeSlv(slv);
      isA  = 1'($urandom);
      b    = ($urandom % 2 == 0) ? slv : 8'($urandom);
      pre  = 1'($urandom);
      ae   = 1'($urandom);
      mode = int'($urandom % 3);
      runByte(b, isA, pre, ae, mode, slv, "random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule